// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block derives the three clocks of a two-channel audio serial port from one module clock: a master clock for the external converter, a bit clock, and a frame (left/right) clock. All state runs on the module clock. The master clock is a divided copy of the module clock. The bit clock is divided from the master clock, so its period in module clocks is the product of the two ratios. The frame clock changes level after every word of bit-clock periods.

The divisors are chosen through small codes in an eight-bit control word. A separate two-bit input selects the word length. Besides the clocks, the block gives a serializer one-cycle strobes that mark each rising and falling bit-clock edge. Codes outside the defined set raise a configuration error and keep every clock quiet. When master operation is off, the block drives nothing and holds its dividers in reset.

Top module: `audclk_gen`

## Requirements
- R1: While `rst_n` is low, all clock outputs, both strobes and `cfg_err` are low at every clock edge, whatever the other inputs are.
- R2: MCLK code (control bits 3:0) values 0..7 select MCLK periods of 1, 2, 4, 6, 8, 12, 16 and 24 module clocks. For every even ratio, MCLK is high for exactly half the period.
- R3: With MCLK code 0 and the block running, `mclk_o` follows the module clock: high while `clk` is high and low while it is low.
- R4: BCLK code (control bits 6:4) values 0..5 select 2, 4, 6, 8, 12 and 16 MCLK periods per BCLK period. BCLK is high for half of its period, measured in module clocks.
- R5: `bclk_rise_stb` is high for exactly the first module-clock cycle in which `bclk_o` is high. `bclk_fall_stb` is high for exactly the first cycle in which `bclk_o` is low again after being high.
- R6: Word code values 0..3 select 16, 20, 24 and 32 bits. `lrclk_o` changes level only in a cycle that carries `bclk_fall_stb`, after every word-length count of BCLK falling edges. The frame period is therefore 2 x word x BCLK ratio x MCLK ratio module clocks.
- R7: A reserved BCLK code (6, 7) or MCLK code (8..15), with master mode and control bit 7 set, raises `cfg_err` one clock later and keeps all clock outputs and strobes low.
- R8: Clearing `master_en` makes all outputs low after the next clock edge, and `cfg_err` stays low. After re-enabling with an even MCLK ratio N, the dividers restart from zero, and MCLK is first seen high after the N/2-th edge.
- R9: Control bit 7 is the clock enable. With it clear, the block stays idle even when `master_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Master mode: the block generates the clocks |
| ctl_word | input | 8 | Bit 7 enable, bits 6:4 BCLK code, bits 3:0 MCLK code |
| word_code | input | 2 | Word length select: 16, 20, 24 or 32 bits |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| bclk_rise_stb | output | 1 | One-cycle mark of a BCLK rising edge |
| bclk_fall_stb | output | 1 | One-cycle mark of a BCLK falling edge |
| cfg_err | output | 1 | Reserved divider code selected while enabled |

## Verification
The hardest case to reach from the ports is a disable that arrives while the frame clock is high and the bit clock is mid-period. From the enable alone, the stimulus cannot tell when that state occurs. The bench therefore runs the fastest divider setting, watches `lrclk_o` until it reads high, and only then drops `master_en` or control bit 7. It then checks that every output is low after a single edge. The one-to-one pass-through of MCLK cannot be seen by sampling once per cycle. The bench samples it in both clock phases.

// File: rtl/audclk_pkg.sv
// Package: shared limits and divider-code decoding for the audio clock divider.
// Assumes codes arrive as raw control-word fields; decode functions flag reserved values.
package audclk_pkg;

    localparam int MDIV_MAX = 24;
    localparam int BDIV_MAX = 16;
    localparam int WLEN_MAX = 32;

    localparam int MR_W = $clog2(MDIV_MAX + 1);
    localparam int BR_W = $clog2(BDIV_MAX + 1);
    localparam int WL_W = $clog2(WLEN_MAX + 1);

    typedef struct packed {
        logic       clk_en;
        logic [2:0] bclk_code;
        logic [3:0] mclk_code;
    } ctl_t;

    function automatic logic [MR_W-1:0] mclk_ratio(input logic [3:0] code);
        case (code)
            4'd0:    return MR_W'(1);
            4'd1:    return MR_W'(2);
            4'd2:    return MR_W'(4);
            4'd3:    return MR_W'(6);
            4'd4:    return MR_W'(8);
            4'd5:    return MR_W'(12);
            4'd6:    return MR_W'(16);
            4'd7:    return MR_W'(24);
            default: return '0;
        endcase
    endfunction

    function automatic logic [BR_W-1:0] bclk_ratio(input logic [2:0] code);
        case (code)
            3'd0:    return BR_W'(2);
            3'd1:    return BR_W'(4);
            3'd2:    return BR_W'(6);
            3'd3:    return BR_W'(8);
            3'd4:    return BR_W'(12);
            3'd5:    return BR_W'(16);
            default: return '0;
        endcase
    endfunction

    function automatic logic [WL_W-1:0] word_len(input logic [1:0] code);
        case (code)
            2'd0:    return WL_W'(16);
            2'd1:    return WL_W'(20);
            2'd2:    return WL_W'(24);
            default: return WL_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/audclk_cfg_decode.sv
// Module: turns the control word into ratios, a run qualifier and a registered error flag.
// Assumes inputs are synchronous to clk; run is combinational so a disable acts on the next edge.
module audclk_cfg_decode
    import audclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_en,
    input  logic [7:0]      ctl_word,
    input  logic [1:0]      word_code,
    output logic            run,
    output logic [MR_W-1:0] m_ratio,
    output logic [BR_W-1:0] b_ratio,
    output logic [WL_W-1:0] w_len,
    output logic            cfg_err
);

    ctl_t ctl;
    logic bad_code;
    logic want;

    // Field split and ratio lookup.
    always_comb begin
        ctl      = ctl_t'(ctl_word);
        m_ratio  = mclk_ratio(ctl.mclk_code);
        b_ratio  = bclk_ratio(ctl.bclk_code);
        w_len    = word_len(word_code);
        bad_code = (m_ratio == '0) || (b_ratio == '0);
        want     = master_en && ctl.clk_en;
        run      = want && !bad_code;
    end

    // Error flag: reserved code selected while clocks are requested.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= want && bad_code;
    end

endmodule

// File: rtl/audclk_div_stage.sv
// Module: integer even-ratio divider that advances on an input tick.
// Assumes ratio is 1 or even; ratio 1 gives a tick per input tick and a low level.
// With STROBES set, it also registers one-cycle edge marks aligned with the level change.
module audclk_div_stage #(
    parameter int W       = 5,
    parameter bit STROBES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         level_o,
    output logic         rise_evt_o,
    output logic         fall_evt_o,
    output logic         rise_stb_o,
    output logic         fall_stb_o
);

    logic [W-1:0] cnt;
    logic [W-1:0] half;
    logic [W-1:0] last;

    // Compare points: rise at half-1, wrap and fall at ratio-1.
    always_comb begin
        half       = (ratio >= W'(2)) ? ((ratio >> 1) - W'(1)) : '0;
        last       = (ratio == '0) ? '0 : (ratio - W'(1));
        rise_evt_o = run && tick && (cnt == half);
        fall_evt_o = run && tick && (cnt >= last);
    end

    // Phase counter and output level; cleared whenever not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            level_o <= 1'b0;
        end else if (tick) begin
            cnt <= fall_evt_o ? '0 : cnt + W'(1);
            if (fall_evt_o)      level_o <= 1'b0;
            else if (rise_evt_o) level_o <= 1'b1;
        end
    end

    generate
        if (STROBES) begin : g_stb
            // Edge marks registered on the same edge as the level change.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    rise_stb_o <= 1'b0;
                    fall_stb_o <= 1'b0;
                end else begin
                    rise_stb_o <= rise_evt_o && !fall_evt_o;
                    fall_stb_o <= fall_evt_o;
                end
            end
        end else begin : g_nostb
            assign rise_stb_o = 1'b0;
            assign fall_stb_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/audclk_frame_ctr.sv
// Module: counts BCLK falling edges and toggles the frame clock every word.
// Assumes fall_evt is a one-cycle event from the bit-clock stage.
module audclk_frame_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         fall_evt,
    input  logic [W-1:0] w_len,
    output logic         lrclk_o
);

    logic [W-1:0] bit_cnt;
    logic         word_end;

    // End of word when the count reaches the last bit.
    always_comb word_end = (bit_cnt >= (w_len - W'(1)));

    // Bit counter and frame level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            bit_cnt <= '0;
            lrclk_o <= 1'b0;
        end else if (fall_evt) begin
            if (word_end) begin
                bit_cnt <= '0;
                lrclk_o <= !lrclk_o;
            end else begin
                bit_cnt <= bit_cnt + W'(1);
            end
        end
    end

endmodule

// File: rtl/audclk_gen.sv
// Module: top of the audio clock divider; MCLK from the module clock, BCLK from MCLK ticks,
// LRCLK from BCLK falls. Assumes one clock domain; MCLK ratio 1 gates the module clock.
module audclk_gen
    import audclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic [7:0] ctl_word,
    input  logic [1:0] word_code,
    output logic       mclk_o,
    output logic       bclk_o,
    output logic       lrclk_o,
    output logic       bclk_rise_stb,
    output logic       bclk_fall_stb,
    output logic       cfg_err
);

    logic            run;
    logic            run_q;
    logic [MR_W-1:0] m_ratio;
    logic [BR_W-1:0] b_ratio;
    logic [WL_W-1:0] w_len;
    logic            mclk_lvl;
    logic            mtick;
    logic            m_fall_unused;
    logic            m_rstb_unused;
    logic            m_fstb_unused;
    logic            b_rise_evt_unused;
    logic            b_fall_evt;

    audclk_cfg_decode u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .ctl_word  (ctl_word),
        .word_code (word_code),
        .run       (run),
        .m_ratio   (m_ratio),
        .b_ratio   (b_ratio),
        .w_len     (w_len),
        .cfg_err   (cfg_err)
    );

    audclk_div_stage #(.W(MR_W), .STROBES(1'b0)) u_mdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (1'b1),
        .ratio      (m_ratio),
        .level_o    (mclk_lvl),
        .rise_evt_o (mtick),
        .fall_evt_o (m_fall_unused),
        .rise_stb_o (m_rstb_unused),
        .fall_stb_o (m_fstb_unused)
    );

    audclk_div_stage #(.W(BR_W), .STROBES(1'b1)) u_bdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (mtick),
        .ratio      (b_ratio),
        .level_o    (bclk_o),
        .rise_evt_o (b_rise_evt_unused),
        .fall_evt_o (b_fall_evt),
        .rise_stb_o (bclk_rise_stb),
        .fall_stb_o (bclk_fall_stb)
    );

    audclk_frame_ctr #(.W(WL_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .fall_evt (b_fall_evt),
        .w_len    (w_len),
        .lrclk_o  (lrclk_o)
    );

    // Registered run, used to gate the module clock for ratio 1.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // MCLK select: pass-through for ratio 1, divided level otherwise.
    always_comb mclk_o = (m_ratio == MR_W'(1)) ? (clk && run_q) : mclk_lvl;

endmodule

// File: rtl/audclk_gen_chk.sv
// Module: temporal checks on the audio clock divider, attached by bind.
// Assumes run is the internal qualifier of the top module.
module audclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic master_en,
    input logic run,
    input logic bclk_o,
    input logic lrclk_o,
    input logic bclk_rise_stb,
    input logic bclk_fall_stb,
    input logic cfg_err
);

    p_rise_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise_stb |-> (bclk_o && !$past(bclk_o)));

    p_fall_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall_stb |-> (!bclk_o && $past(bclk_o)));

    p_bclk_rose_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_o) |-> bclk_rise_stb);

    p_lr_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (lrclk_o != $past(lrclk_o))) |-> bclk_fall_stb);

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!bclk_o && !lrclk_o && !bclk_rise_stb && !bclk_fall_stb));

    p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!bclk_o && !lrclk_o && !bclk_rise_stb && !cfg_err));

endmodule

bind audclk_gen audclk_gen_chk u_audclk_gen_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .master_en     (master_en),
    .run           (run),
    .bclk_o        (bclk_o),
    .lrclk_o       (lrclk_o),
    .bclk_rise_stb (bclk_rise_stb),
    .bclk_fall_stb (bclk_fall_stb),
    .cfg_err       (cfg_err)
);

// File: tb/test_audclk_gen.sv
module test_audclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic [7:0] ctl_word = 8'h00;
    logic [1:0] word_code = 2'd0;
    logic       mclk_o, bclk_o, lrclk_o, bclk_rise_stb, bclk_fall_stb, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_per, m_hi, b_per, b_hi, l_per, stb_bad, lr_bad;

    always #4 clk = ~clk;

    audclk_gen i_audclk_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_en     (master_en),
        .ctl_word      (ctl_word),
        .word_code     (word_code),
        .mclk_o        (mclk_o),
        .bclk_o        (bclk_o),
        .lrclk_o       (lrclk_o),
        .bclk_rise_stb (bclk_rise_stb),
        .bclk_fall_stb (bclk_fall_stb),
        .cfg_err       (cfg_err)
    );

    // mclk code, bclk code, word code, MCLK period, BCLK period, frame period (module clocks)
    localparam int unsigned VEC [0:7][0:5] = '{
        '{1, 0, 0,  2,   4,  128},
        '{0, 1, 1,  1,   4,  160},
        '{2, 2, 2,  4,  24, 1152},
        '{3, 3, 3,  6,  48, 3072},
        '{4, 4, 0,  8,  96, 3072},
        '{5, 5, 0, 12, 192, 6144},
        '{6, 0, 1, 16,  32, 1280},
        '{7, 1, 2, 24,  96, 4608}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic observe(input int cycles);
        logic pm, pb, pl;
        int mr, br, lr;
        mr = -1; br = -1; lr = -1;
        m_per = 0; m_hi = 0; b_per = 0; b_hi = 0; l_per = 0; stb_bad = 0; lr_bad = 0;
        step();
        pm = mclk_o; pb = bclk_o; pl = lrclk_o;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (mclk_o && !pm) begin if (mr >= 0) m_per = i - mr; mr = i; end
            if (!mclk_o && pm && mr >= 0) m_hi = i - mr;
            if (bclk_o && !pb) begin if (br >= 0) b_per = i - br; br = i; end
            if (!bclk_o && pb && br >= 0) b_hi = i - br;
            if (lrclk_o && !pl) begin if (lr >= 0) l_per = i - lr; lr = i; end
            if (bclk_rise_stb != (bclk_o && !pb)) stb_bad++;
            if (bclk_fall_stb != (!bclk_o && pb)) stb_bad++;
            if ((lrclk_o != pl) && !bclk_fall_stb) lr_bad++;
            pm = mclk_o; pb = bclk_o; pl = lrclk_o;
        end
    endtask

    task automatic all_low(input string req);
        chk({req, " mclk"}, int'(mclk_o), 0);
        chk({req, " bclk"}, int'(bclk_o), 0);
        chk({req, " lrclk"}, int'(lrclk_o), 0);
        chk({req, " strobes"}, int'(bclk_rise_stb | bclk_fall_stb), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi_bad, quiet_bad;
        // R1: reset dominates an enabled configuration.
        master_en = 1'b1;
        ctl_word  = 8'h81;
        repeat (5) step();
        all_low("R1 reset");
        chk("R1 reset cfg_err", int'(cfg_err), 0);
        master_en = 1'b0;
        step();
        rst_n = 1'b1;
        step();

        // R2 R4 R5 R6 R9: table of ratio settings.
        for (int v = 0; v < 8; v++) begin
            master_en = 1'b0;
            ctl_word  = {1'b1, 3'(VEC[v][1]), 4'(VEC[v][0])};
            word_code = 2'(VEC[v][2]);
            repeat (2) step();
            master_en = 1'b1;
            observe(int'(2 * VEC[v][5] + 64));
            if (VEC[v][3] > 1) begin
                chk("R2 mclk period", m_per, int'(VEC[v][3]));
                chk("R2 mclk high time", m_hi, int'(VEC[v][3] / 2));
            end
            chk("R4 bclk period", b_per, int'(VEC[v][4]));
            chk("R4 bclk high time", b_hi, int'(VEC[v][4] / 2));
            chk("R6 frame period", l_per, int'(VEC[v][5]));
            chk("R5 strobe alignment", stb_bad, 0);
            chk("R6 lrclk on bclk fall", lr_bad, 0);
        end

        // R3: ratio 1 follows the module clock in both phases.
        master_en = 1'b0;
        ctl_word  = 8'h80;
        step();
        master_en = 1'b1;
        repeat (3) step();
        hi_bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #2;
            if (mclk_o !== 1'b1) hi_bad++;
            @(negedge clk); #2;
            if (mclk_o !== 1'b0) hi_bad++;
        end
        chk("R3 mclk pass-through", hi_bad, 0);

        // R8: restart from zero, ratio 4 rises after the second edge.
        master_en = 1'b0;
        ctl_word  = 8'h82;
        repeat (2) step();
        master_en = 1'b1;
        step();
        chk("R8 restart mclk after edge 1", int'(mclk_o), 0);
        step();
        chk("R8 restart mclk after edge 2", int'(mclk_o), 1);

        // R8: disable while lrclk is high.
        master_en = 1'b0;
        ctl_word  = 8'h81;
        word_code = 2'd0;
        step();
        master_en = 1'b1;
        for (int k = 0; k < 400 && !lrclk_o; k++) step();
        chk("R8 lrclk reached high", int'(lrclk_o), 1);
        master_en = 1'b0;
        step();
        all_low("R8 disable");
        chk("R8 cfg_err stays low", int'(cfg_err), 0);

        // R9: clearing control bit 7 idles the block mid-frame.
        master_en = 1'b1;
        for (int k = 0; k < 400 && !lrclk_o; k++) step();
        ctl_word = 8'h01;
        step();
        all_low("R9 enable bit clear");
        quiet_bad = 0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (mclk_o || bclk_o || lrclk_o || cfg_err) quiet_bad++;
        end
        chk("R9 idle with bit 7 clear", quiet_bad, 0);

        // R7: reserved BCLK code.
        ctl_word = 8'hE0;
        step();
        chk("R7 cfg_err on bclk code 6", int'(cfg_err), 1);
        quiet_bad = 0;
        for (int k = 0; k < 200; k++) begin
            step();
            if (mclk_o || bclk_o || lrclk_o || bclk_rise_stb || bclk_fall_stb) quiet_bad++;
        end
        chk("R7 outputs quiet on bclk code 6", quiet_bad, 0);

        // R7: reserved MCLK code.
        ctl_word = 8'h89;
        step();
        chk("R7 cfg_err on mclk code 9", int'(cfg_err), 1);
        quiet_bad = 0;
        for (int k = 0; k < 200; k++) begin
            step();
            if (mclk_o || bclk_o || lrclk_o || bclk_rise_stb || bclk_fall_stb) quiet_bad++;
        end
        chk("R7 outputs quiet on mclk code 9", quiet_bad, 0);

        // R8: reserved code with master mode off raises no error.
        master_en = 1'b0;
        step();
        chk("R8 no error when master off", int'(cfg_err), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule